// File: doc/BRIEF.md
# Interrupt Status Mask Coalescer

This block collects event bits for a network interface into a 32-bit status register, filters them through a 32-bit mask, and drives one interrupt line to the CPU. Event sources post bits with a one-cycle pulse vector. Software reaches four registers through a plain register port: status, mask, a control register holding the global enable, and a holdoff value.

A masked event does not raise the line at once. It arms a holdoff down-counter, and the line rises when the counter expires. Bits of the urgent class skip the holdoff and raise the line on the edge that records them. A new request replaces the running deadline only if it would fire sooner. Reading the status register returns its value and clears it, and a clear that leaves no masked bit set drops the line and cancels any armed deadline. Bits of the reserved class are never stored, and an attempt to post or clear one raises a one-cycle error flag.

Register map (`reg_addr`): 0 status (a read clears all of it, a write clears the bits written as 1), 1 mask, 2 control (bit 0 is the global enable), 3 holdoff (low `HOLD_W` bits, in cycles). Reads are combinational from the current register values. Parameters set the classes: reserved bits `RSVD_MASK` = 0xFF00_0000, urgent bits `URGENT_MASK` = 0x0000_0101.

Top module: `isr_coalescer`

## Requirements
- R1: A posted non-reserved bit is set in status after the clock edge. When a post and a clear (by read or by a 1 written to status) of the same bit fall in the same cycle, the bit ends up set.
- R2: Bits 31..24 are reserved. A post or a status write that carries any of them leaves those bits at 0 in status, still applies the other bits, and drives `err_o` high for the one cycle after that edge.
- R3: A read of address 0 returns the status value of that cycle, and the status becomes 0 after the edge. If no masked bit is then set, the line is low after the edge and any armed deadline is cancelled.
- R4: Writing status clears each non-reserved bit written as 1 and leaves the others; if no masked bit remains, the line drops and the deadline is cancelled.
- R5: With the enable set and holdoff H >= 1, a post of a masked non-urgent bit raises the line at the H-th edge after the edge that records the post; with H = 0 it rises at that same edge.
- R6: When a post leaves any urgent bit (bits 0 and 8) set in masked status, the line rises at the edge that records the post.
- R7: A new delayed request with H smaller than the edges left on the armed deadline replaces it; an equal or larger H keeps the earlier deadline.
- R8: Writing a mask equal to the current one changes nothing. A different mask raises the line at once when status AND new mask is nonzero, otherwise drops the line and cancels the deadline.
- R9: Writing enable 0 drops the line and cancels the deadline; while the enable is 0 the line never rises; writing 1 when it was 0 raises the line at once if masked status is nonzero.
- R10: After reset status is 0, the mask is 0x0000_002A (bit 1 rx-data-done, bit 3 tx-fifo-low, bit 5 rx-fifo-high), the enable is 0, the holdoff is 8, the line and `err_o` are low.
- R11: Whenever the line is high, the enable is set and status AND mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_post | input | 32 | One-cycle event pulses, one bit per event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 holdoff |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data of the selected register |
| irq_o | output | 1 | Interrupt line to the CPU |
| err_o | output | 1 | Reserved-bit access flag, one cycle |

## Verification
The read-to-clear of status and an event post can land in the same cycle, and so can a delayed post and an already running holdoff deadline. The bench drives reads of status while posts arrive, both in directed steps and with random stimulus, and judges the stored status and the line against a cycle model built from the requirements. Competing deadlines are provoked by changing the holdoff between two posts, and the model decides which deadline must fire.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_HOLD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RSVD_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_post,
  input  logic [W-1:0] clr_vec,
  input  logic         rd_clr,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d,
  output logic [W-1:0] post_eff,
  output logic         err_o
);
  logic [W-1:0] clr_eff;
  logic         err_d;

  assign post_eff = evt_post & ~RSVD_MASK;
  assign clr_eff  = clr_vec & ~RSVD_MASK;
  // A set in the same cycle overrides any clear.
  assign status_d = (rd_clr ? '0 : (status_q & ~clr_eff)) | post_eff;
  assign err_d    = (|(evt_post & RSVD_MASK)) | (|(clr_vec & RSVD_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      err_o    <= 1'b0;
    end else begin
      status_q <= status_d;
      err_o    <= err_d;
    end
  end
endmodule

// File: rtl/isr_holdoff_sched.sv
module isr_holdoff_sched #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              req_now,
  input  logic              req_delay,
  input  logic [HOLD_W-1:0] hold,
  output logic              irq_o,
  output logic              sched_q,
  output logic [HOLD_W-1:0] cnt_q
);
  logic              irq_d, sched_d;
  logic [HOLD_W-1:0] cnt_d;

  always_comb begin
    irq_d   = irq_o;
    sched_d = sched_q;
    cnt_d   = cnt_q;
    if (kill) begin
      irq_d   = 1'b0;
      sched_d = 1'b0;
      cnt_d   = '0;
    end else if (req_now || (req_delay && hold == '0)) begin
      irq_d   = 1'b1;
      sched_d = 1'b0;
      cnt_d   = '0;
    end else if (req_delay && (!sched_q || hold < cnt_q)) begin
      // only an earlier deadline may replace the armed one
      sched_d = 1'b1;
      cnt_d   = hold;
    end else if (sched_q) begin
      if (cnt_q == HOLD_W'(1)) begin
        irq_d   = 1'b1;
        sched_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - HOLD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o   <= 1'b0;
      sched_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      irq_o   <= irq_d;
      sched_q <= sched_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/isr_coalescer.sv
module isr_coalescer #(
  parameter int           W           = 32,
  parameter int           HOLD_W      = 16,
  parameter logic [W-1:0] RSVD_MASK   = 32'hFF00_0000,
  parameter logic [W-1:0] URGENT_MASK = 32'h0000_0101,
  parameter logic [W-1:0] RST_MASK    = 32'h0000_002A,
  parameter int           RST_HOLD    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_post,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_o,
  output logic         err_o
);
  import isr_pkg::*;

  localparam int PAD_W = W - HOLD_W;

  reg_sel_e          sel;
  logic [W-1:0]      status_q, status_d, post_eff, clr_vec, mask_q, mask_d;
  logic              ien_q, ien_d, hold_wr;
  logic [HOLD_W-1:0] hold_q, cnt_q;
  logic              sched_q, rd_clr, mask_chg, en_rise, masked_nz;
  logic              kill, req_now, req_delay;

  assign sel     = reg_sel_e'(reg_addr);
  assign rd_clr  = reg_rd && sel == SEL_STATUS;
  assign clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
  assign hold_wr = reg_wr && sel == SEL_HOLD;

  assign mask_d   = (reg_wr && sel == SEL_MASK) ? reg_wdata : mask_q;
  assign mask_chg = reg_wr && sel == SEL_MASK && reg_wdata != mask_q;
  assign ien_d    = (reg_wr && sel == SEL_CTRL) ? reg_wdata[0] : ien_q;
  assign en_rise  = ien_d && !ien_q;

  isr_status_bank #(.W(W), .RSVD_MASK(RSVD_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_post (evt_post),
    .clr_vec  (clr_vec),
    .rd_clr   (rd_clr),
    .status_q (status_q),
    .status_d (status_d),
    .post_eff (post_eff),
    .err_o    (err_o)
  );

  assign masked_nz = |(status_d & mask_d);
  assign kill      = !ien_d || !masked_nz;
  assign req_delay = |post_eff;
  assign req_now   = mask_chg || en_rise ||
                     (req_delay && |(status_d & mask_d & URGENT_MASK));

  isr_holdoff_sched #(.HOLD_W(HOLD_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (kill),
    .req_now   (req_now),
    .req_delay (req_delay),
    .hold      (hold_q),
    .irq_o     (irq_o),
    .sched_q   (sched_q),
    .cnt_q     (cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_MASK;
      ien_q  <= 1'b0;
      hold_q <= HOLD_W'(RST_HOLD);
    end else begin
      mask_q <= mask_d;
      ien_q  <= ien_d;
      if (hold_wr) hold_q <= reg_wdata[HOLD_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = status_q;
      SEL_MASK:   reg_rdata = mask_q;
      SEL_CTRL:   reg_rdata = {{(W-1){1'b0}}, ien_q};
      default:    reg_rdata = {{PAD_W{1'b0}}, hold_q};
    endcase
  end
endmodule

// File: rtl/isr_coalescer_chk.sv
module isr_coalescer_chk #(
  parameter int           W           = 32,
  parameter int           HOLD_W      = 16,
  parameter logic [W-1:0] RSVD_MASK   = 32'hFF00_0000,
  parameter logic [W-1:0] URGENT_MASK = 32'h0000_0101
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      evt_post,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic              irq_o,
  input logic              err_o,
  input logic [W-1:0]      status_q,
  input logic [W-1:0]      mask_q,
  input logic              ien_q,
  input logic              sched_q,
  input logic [HOLD_W-1:0] cnt_q
);
  assert_line_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien_q && (status_q & mask_q) != '0));

  assert_post_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_post & ~RSVD_MASK) != '0 |=>
      (status_q & $past(evt_post & ~RSVD_MASK)) == $past(evt_post & ~RSVD_MASK));

  assert_reserved_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_post & RSVD_MASK) != '0 |=> err_o);

  assert_reserved_never_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RSVD_MASK) == '0);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && evt_post == '0) |=> (status_q == '0 && !irq_o && !sched_q));

  assert_urgent_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && ien_q && (evt_post & URGENT_MASK & mask_q) != '0) |=> irq_o);

  assert_disable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && !reg_wdata[0]) |=> (!irq_o && !sched_q));

  assert_armed_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sched_q |-> cnt_q != '0);
endmodule

bind isr_coalescer isr_coalescer_chk #(
  .W(W), .HOLD_W(HOLD_W), .RSVD_MASK(RSVD_MASK), .URGENT_MASK(URGENT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_post(evt_post), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o), .err_o(err_o),
  .status_q(status_q), .mask_q(mask_q), .ien_q(ien_q), .sched_q(sched_q), .cnt_q(cnt_q)
);

// File: tb/test_isr_coalescer.sv
module test_isr_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RSVD = 32'hFF00_0000;
  localparam logic [31:0] URG  = 32'h0000_0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_post = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, err_o;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [31:0] m_status, m_mask;
  logic        m_en, m_irq, m_sched, m_err;
  logic [15:0] m_hold, m_cnt;

  isr_coalescer i_isr_coalescer (
    .clk(clk), .rst_n(rst_n), .evt_post(evt_post), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_status;
      2'd1: return m_mask;
      2'd2: return {31'b0, m_en};
      default: return {16'b0, m_hold};
    endcase
  endfunction

  task automatic model_edge(input logic [31:0] p, input logic wr, input logic rd,
                            input logic [1:0] a, input logic [31:0] wd);
    logic [31:0] pe, ce, s_n, mk_n;
    logic chg, en_n, rise;
    pe   = p & ~RSVD;
    ce   = (wr && a == 2'd0) ? (wd & ~RSVD) : '0;
    s_n  = ((rd && a == 2'd0) ? 32'h0 : (m_status & ~ce)) | pe;
    mk_n = (wr && a == 2'd1) ? wd : m_mask;
    chg  = wr && a == 2'd1 && wd != m_mask;
    en_n = (wr && a == 2'd2) ? wd[0] : m_en;
    rise = en_n && !m_en;
    m_err = (|(p & RSVD)) || (wr && a == 2'd0 && |(wd & RSVD));
    if (!en_n || (s_n & mk_n) == '0) begin
      m_irq = 0; m_sched = 0; m_cnt = 0;
    end else if (chg || rise || (pe != '0 && ((s_n & mk_n & URG) != '0 || m_hold == 0))) begin
      m_irq = 1; m_sched = 0; m_cnt = 0;
    end else if (pe != '0 && (!m_sched || m_hold < m_cnt)) begin
      m_sched = 1; m_cnt = m_hold;
    end else if (m_sched) begin
      if (m_cnt == 1) begin m_irq = 1; m_sched = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
    end
    if (wr && a == 2'd3) m_hold = wd[15:0];
    m_status = s_n; m_mask = mk_n; m_en = en_n;
  endtask

  // one cycle: drive after a falling edge, check read data, then line and flag after the rising edge
  task automatic step(input logic [31:0] p, input logic wr, input logic rd,
                      input logic [1:0] a, input logic [31:0] wd, input string req);
    evt_post = p; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd) check(reg_rdata, model_read(a), req);
    model_edge(p, wr, rd, a, wd);
    @(posedge clk); #1;
    check({31'b0, irq_o}, {31'b0, m_irq}, req);
    check({31'b0, err_o}, {31'b0, m_err}, "R2");
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step('0, 0, 0, 2'd0, '0, req);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] v, input string req);
    step('0, 1, 0, a, v, req);
  endtask

  task automatic rreg(input logic [1:0] a, input string req);
    step('0, 0, 1, a, '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    m_status = '0; m_mask = 32'h0000_002A; m_en = 0; m_irq = 0; m_sched = 0;
    m_err = 0; m_hold = 16'd8; m_cnt = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset values
    check({31'b0, irq_o}, 32'h0, "R10");
    check({31'b0, err_o}, 32'h0, "R10");
    rreg(2'd0, "R10"); rreg(2'd1, "R10"); rreg(2'd2, "R10"); rreg(2'd3, "R10");

    // R9: post while disabled never raises the line
    step(32'h2, 0, 0, 2'd0, '0, "R9"); idle(10, "R9");
    wreg(2'd2, 32'h1, "R9");             // enable with masked status set: at once
    wreg(2'd2, 32'h0, "R9");             // drop
    rreg(2'd0, "R3");
    wreg(2'd2, 32'h1, "R9");

    // R5: holdoff of 3, then 0
    wreg(2'd3, 32'd3, "R5");
    step(32'h2, 0, 0, 2'd0, '0, "R5"); idle(5, "R5");
    rreg(2'd0, "R3"); idle(1, "R3");
    wreg(2'd3, 32'd0, "R5");
    step(32'h8, 0, 0, 2'd0, '0, "R5");
    rreg(2'd0, "R3");

    // R3: read cancels an armed deadline
    wreg(2'd3, 32'd4, "R3");
    step(32'h2, 0, 0, 2'd0, '0, "R3"); idle(1, "R3");
    rreg(2'd0, "R3"); idle(6, "R3");

    // R6: urgent bit skips the holdoff
    wreg(2'd1, 32'h0000_012B, "R8");
    step(32'h100, 0, 0, 2'd0, '0, "R6");
    rreg(2'd0, "R3");

    // R7: earlier deadline replaces, later keeps
    wreg(2'd3, 32'd6, "R7");
    step(32'h2, 0, 0, 2'd0, '0, "R7"); idle(1, "R7");
    wreg(2'd3, 32'd1, "R7");
    step(32'h8, 0, 0, 2'd0, '0, "R7"); idle(2, "R7");
    rreg(2'd0, "R3");
    wreg(2'd3, 32'd3, "R7");
    step(32'h2, 0, 0, 2'd0, '0, "R7");
    wreg(2'd3, 32'd7, "R7");
    step(32'h8, 0, 0, 2'd0, '0, "R7"); idle(4, "R7");
    rreg(2'd0, "R3");

    // R8: same mask does nothing, new mask drops or raises
    wreg(2'd3, 32'd5, "R8");
    step(32'h2, 0, 0, 2'd0, '0, "R8");
    wreg(2'd1, 32'h0000_012B, "R8"); idle(5, "R8");
    wreg(2'd1, 32'h0000_0000, "R8");
    wreg(2'd1, 32'h0000_0002, "R8");
    rreg(2'd1, "R8");

    // R2 / R4 / R1: reserved post, write-one-clear, post beats clear
    step(32'h0100_0020, 0, 0, 2'd0, '0, "R2");
    rreg(2'd0, "R2");
    wreg(2'd1, 32'h0000_002A, "R8");
    step(32'h0000_0028, 0, 0, 2'd0, '0, "R4");
    wreg(2'd0, 32'h8000_0008, "R4");
    rreg(2'd0, "R4");
    wreg(2'd0, 32'h0000_0020, "R4");
    step(32'h0000_0002, 1, 0, 2'd0, 32'h0000_0002, "R1");
    rreg(2'd0, "R1");
    step(32'h0000_0008, 0, 1, 2'd0, '0, "R1");
    rreg(2'd0, "R1");

    // random mix, every cycle judged against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p, wd;
      logic wr, rd;
      logic [1:0] a;
      int r;
      r  = $urandom_range(0, 99);
      p  = (r < 30) ? (32'h1 << $urandom_range(0, 8)) : '0;
      if ($urandom_range(0, 49) == 0) p = p | 32'h0400_0000;
      wr = 0; rd = 0; a = 2'($urandom_range(0, 3)); wd = '0;
      r  = $urandom_range(0, 99);
      if (r < 12) rd = 1;
      else if (r < 20) begin
        wr = 1;
        case (a)
          2'd0: wd = 32'h1 << $urandom_range(0, 31);
          2'd1: wd = {23'b0, 9'($urandom)};
          2'd2: wd = {31'b0, ($urandom_range(0, 3) != 0)};
          default: wd = 32'($urandom_range(0, 6));
        endcase
      end
      step(p, wr, rd, a, wd, "R11");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule